// File: doc/BRIEF.md
# Dual-Style Host Register Port for a Tone Transceiver

This block is the host-facing register port of a tone-signalling transceiver. A host processor reaches it over a 4-bit data bus and can use either of two strobe conventions on the same pins. In the first convention, one pin carries a read/write level and a second pin carries an active-high data strobe. In the second convention, the same two pins carry separate active-low write and read strobes. The level on a mode input during reset picks the convention, and the block keeps it until the next reset. All bus pins pass through a synchroniser. Writes take effect on the trailing edge of the active strobe.

The port holds a transmit digit register, a primary control register and a secondary control register. Both control registers are written at one shared address: setting the steering bit in the primary register sends the next control write to the secondary register. Reads return either the latest received digit or a status nibble, and a status read clears the pending event flags. The primary control register also holds the power controls. The transmit and receive paths are enabled independently. When both are disabled, the shared oscillator enable falls and the data bus, the tone output enable and the interrupt pull-down are all held released, even during a read.

Top module: `dhr_top`

## Requirements
- R1: After reset, both control registers and the transmit digit are 0. tx_en_o, rx_en_o, osc_en_o, tone_oe_o, irq_pull_o and data_oe_o are all 0.
- R2: bus_mode_i is captured while rst_n is low and ignored afterwards. With mode 0, strb_a_i is read/write (1 = read, 0 = write) and strb_b_i is an active-high data strobe. With mode 1, strb_a_i is an active-low write strobe and strb_b_i is an active-low read strobe.
- R3: data_oe_o is 1 only while cs_n_i is 0 and a read is under way, and the block is not fully powered down. In mode 0 a read is under way when strb_b_i is 1 and strb_a_i is 1. In mode 1 a read is under way when strb_b_i is 0.
- R4: A write with sel_i = 0 loads tx_data_o. A read with sel_i = 0 returns the digit from rx_data_i that was captured at the last rx_valid_i pulse while receive was enabled. Pulses that arrive while receive is disabled leave the stored digit unchanged.
- R5: Writes with sel_i = 1 go to the primary control register. The primary register's bits are: bit 0 transmit enable, bit 1 interrupt enable, bit 2 receive enable, bit 3 steering. When steering is 1, the next sel_i = 1 write goes to the secondary register (ctrl_b_o) and clears the steering bit; the other primary bits are kept.
- R6: tx_en_o and tone_oe_o follow primary bit 0. rx_en_o follows primary bit 2. osc_en_o is 1 when either of these two bits is 1.
- R7: When primary bits 0 and 2 are both 0, data_oe_o, tone_oe_o and irq_pull_o are 0 whatever the bus pins do.
- R8: A read with sel_i = 1 returns the status nibble. Bit 0 is transmit-done, set by tx_done_i while transmit is enabled. Bit 1 is receive-ready, set by rx_valid_i while receive is enabled. Bit 2 is the current interrupt output. Bit 3 is 0.
- R9: irq_pull_o is 1 when interrupt enable is 1, at least one event flag is set, and the block is not fully powered down.
- R10: The trailing edge of a status read clears both event flags and releases irq_pull_o. An event that arrives in the same cycle as the clear is kept.
- R11: No register changes while the write strobe is still active. The write commits within four clock cycles after the strobe ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_mode_i | input | 1 | Strobe convention, captured during reset |
| cs_n_i | input | 1 | Active-low chip select |
| sel_i | input | 1 | Register select: 0 digit registers, 1 control/status |
| strb_a_i | input | 1 | Read/write level (mode 0) or write strobe, active low (mode 1) |
| strb_b_i | input | 1 | Data strobe, active high (mode 0) or read strobe, active low (mode 1) |
| data_i | input | 4 | Write data from the host |
| data_o | output | 4 | Read data to the host |
| data_oe_o | output | 1 | Data bus drive enable |
| tx_data_o | output | 4 | Digit to transmit |
| ctrl_b_o | output | 4 | Secondary control register |
| tx_en_o | output | 1 | Transmit path enable |
| rx_en_o | output | 1 | Receive path enable |
| osc_en_o | output | 1 | Shared oscillator and reference enable |
| tone_oe_o | output | 1 | Tone output drive enable |
| irq_pull_o | output | 1 | Interrupt pull-down, 1 pulls the open-drain line low |
| rx_data_i | input | 4 | Received digit |
| rx_valid_i | input | 1 | One-cycle pulse when a received digit is valid |
| tx_done_i | input | 1 | One-cycle pulse when a tone burst has been sent |

## Verification
The bench uses the default synchroniser depth of two stages. With that depth the commit delay after a strobe ends is fixed, so each check can be sampled a known number of cycles later. The bench also looks in the middle of a held write strobe to confirm that nothing has changed yet. The bench resets the block once in each bus mode. This exercises the pin pattern that counts as a read in one mode but is idle in the other. It also exercises a mode-input change after reset that must have no effect.

// File: rtl/dhr_pkg.sv
package dhr_pkg;
    localparam int unsigned DW = 4;

    // primary control register bit positions
    localparam int unsigned A_TXEN  = 0;
    localparam int unsigned A_IRQEN = 1;
    localparam int unsigned A_RXEN  = 2;
    localparam int unsigned A_STEER = 3;

    // status nibble bit positions
    localparam int unsigned S_TXF = 0;
    localparam int unsigned S_RXF = 1;
    localparam int unsigned S_IRQ = 2;

    typedef struct packed {
        logic [DW-1:0] ctrl_a;
        logic [DW-1:0] ctrl_b;
        logic [DW-1:0] txd;
        logic [DW-1:0] rxd;
        logic          tx_flag;
        logic          rx_flag;
    } regs_t;

    typedef struct packed {
        logic          wr_prev;
        logic          rd_prev;
        logic          sel;
        logic [DW-1:0] dat;
    } strobe_t;
endpackage

// File: rtl/dhr_sync.sv
module dhr_sync #(
    parameter int unsigned W      = 1,
    parameter int unsigned STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    localparam int unsigned CW = W * STAGES;

    logic [CW-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[W-1:0] = din;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s*W +: W] = chain_q[(s-1)*W +: W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[CW-1 -: W];
endmodule

// File: rtl/dhr_strobe.sv
module dhr_strobe
    import dhr_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_i,
    input  logic          cs_n_s,
    input  logic          pa_s,
    input  logic          pb_s,
    input  logic          sel_s,
    input  logic [DW-1:0] dat_s,
    output logic          mode_o,
    output logic          wr_commit_o,
    output logic          rd_commit_o,
    output logic          sel_o,
    output logic [DW-1:0] dat_o
);
    strobe_t st_d, st_q;
    logic    mode_q;
    logic    wr_act, rd_act;

    // convention chosen while reset is held, frozen afterwards
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= mode_i;
        else        mode_q <= mode_q;
    end

    always_comb begin
        wr_act = !cs_n_s && (mode_q ? !pa_s : (pb_s && !pa_s));
        rd_act = !cs_n_s && (mode_q ? !pb_s : (pb_s &&  pa_s));
        st_d         = st_q;
        st_d.wr_prev = wr_act;
        st_d.rd_prev = rd_act;
        if (wr_act || rd_act) begin
            st_d.sel = sel_s;
            st_d.dat = dat_s;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mode_o      = mode_q;
    assign wr_commit_o = st_q.wr_prev && !wr_act;
    assign rd_commit_o = st_q.rd_prev && !rd_act;
    assign sel_o       = st_q.sel;
    assign dat_o       = st_q.dat;

    AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(mode_q)); // R2
    AST_WR_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit_o |=> !wr_commit_o); // R11
endmodule

// File: rtl/dhr_regs.sv
module dhr_regs
    import dhr_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_commit_i,
    input  logic          rd_commit_i,
    input  logic          sel_i,
    input  logic [DW-1:0] dat_i,
    input  logic          tx_done_i,
    input  logic          rx_valid_i,
    input  logic [DW-1:0] rx_data_i,
    output regs_t         regs_o
);
    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_commit_i) begin
            if (!sel_i) begin
                r_d.txd = dat_i;
            end else if (r_q.ctrl_a[A_STEER]) begin
                r_d.ctrl_b            = dat_i;
                r_d.ctrl_a[A_STEER]   = 1'b0;
            end else begin
                r_d.ctrl_a = dat_i;
            end
        end
        if (rd_commit_i && sel_i) begin
            r_d.tx_flag = 1'b0;
            r_d.rx_flag = 1'b0;
        end
        if (tx_done_i && r_q.ctrl_a[A_TXEN]) begin
            r_d.tx_flag = 1'b1;
        end
        if (rx_valid_i && r_q.ctrl_a[A_RXEN]) begin
            r_d.rx_flag = 1'b1;
            r_d.rxd     = rx_data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign regs_o = r_q;

    AST_STEER_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_commit_i && sel_i && r_q.ctrl_a[A_STEER]) |=> !r_q.ctrl_a[A_STEER]); // R5
    AST_STATUS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_commit_i && sel_i && !tx_done_i && !rx_valid_i) |=> (!r_q.tx_flag && !r_q.rx_flag)); // R10
    AST_CTRL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_commit_i |=> ($stable(r_q.ctrl_a) && $stable(r_q.ctrl_b) && $stable(r_q.txd))); // R11
endmodule

// File: rtl/dhr_top.sv
module dhr_top
    import dhr_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_mode_i,
    input  logic          cs_n_i,
    input  logic          sel_i,
    input  logic          strb_a_i,
    input  logic          strb_b_i,
    input  logic [DW-1:0] data_i,
    output logic [DW-1:0] data_o,
    output logic          data_oe_o,
    output logic [DW-1:0] tx_data_o,
    output logic [DW-1:0] ctrl_b_o,
    output logic          tx_en_o,
    output logic          rx_en_o,
    output logic          osc_en_o,
    output logic          tone_oe_o,
    output logic          irq_pull_o,
    input  logic [DW-1:0] rx_data_i,
    input  logic          rx_valid_i,
    input  logic          tx_done_i
);
    localparam int unsigned BUS_W = DW + 4;
    localparam logic [BUS_W-1:0] BUS_IDLE = {1'b1, {(BUS_W-1){1'b0}}};

    logic [BUS_W-1:0] bus_s;
    logic             mode;
    logic             wr_commit, rd_commit, lat_sel;
    logic [DW-1:0]    lat_dat;
    regs_t            regs;
    logic             full_pd, rd_pins, irq;
    logic [DW-1:0]    status;

    dhr_sync #(.W(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL(BUS_IDLE)) i_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({cs_n_i, strb_a_i, strb_b_i, sel_i, data_i}),
        .dout (bus_s)
    );

    dhr_strobe i_strobe (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_i     (bus_mode_i),
        .cs_n_s     (bus_s[DW+3]),
        .pa_s       (bus_s[DW+2]),
        .pb_s       (bus_s[DW+1]),
        .sel_s      (bus_s[DW]),
        .dat_s      (bus_s[DW-1:0]),
        .mode_o     (mode),
        .wr_commit_o(wr_commit),
        .rd_commit_o(rd_commit),
        .sel_o      (lat_sel),
        .dat_o      (lat_dat)
    );

    dhr_regs i_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_commit_i(wr_commit),
        .rd_commit_i(rd_commit),
        .sel_i      (lat_sel),
        .dat_i      (lat_dat),
        .tx_done_i  (tx_done_i),
        .rx_valid_i (rx_valid_i),
        .rx_data_i  (rx_data_i),
        .regs_o     (regs)
    );

    always_comb begin
        full_pd = !regs.ctrl_a[A_TXEN] && !regs.ctrl_a[A_RXEN];
        irq     = regs.ctrl_a[A_IRQEN] && (regs.tx_flag || regs.rx_flag) && !full_pd;
        // the bus side is asynchronous: the output enable follows the raw pins
        rd_pins = !cs_n_i && (mode ? !strb_b_i : (strb_b_i && strb_a_i));
        status         = '0;
        status[S_TXF]  = regs.tx_flag;
        status[S_RXF]  = regs.rx_flag;
        status[S_IRQ]  = irq;
    end

    assign data_o     = sel_i ? status : regs.rxd;
    assign data_oe_o  = rd_pins && !full_pd;
    assign tx_data_o  = regs.txd;
    assign ctrl_b_o   = regs.ctrl_b;
    assign tx_en_o    = regs.ctrl_a[A_TXEN];
    assign rx_en_o    = regs.ctrl_a[A_RXEN];
    assign osc_en_o   = !full_pd;
    assign tone_oe_o  = regs.ctrl_a[A_TXEN];
    assign irq_pull_o = irq;

    AST_PD_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_en_o |-> (!data_oe_o && !irq_pull_o && !tone_oe_o)); // R7
    AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pull_o |-> (regs.tx_flag || regs.rx_flag)); // R9
endmodule

// File: tb/test_dhr_top.sv
module test_dhr_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_mode = 1'b0;
    logic       cs_n = 1'b1, sel = 1'b0, pa = 1'b1, pb = 1'b0;
    logic [3:0] din = 4'h0;
    logic [3:0] dout, txd, ctlb, rxd = 4'h0;
    logic       oe, tx_en, rx_en, osc_en, tone_oe, irq;
    logic       rx_valid = 1'b0, tx_done = 1'b0;
    int         total = 0, bad = 0;

    always #4 clk = ~clk;

    dhr_top i_dhr_top (
        .clk(clk), .rst_n(rst_n), .bus_mode_i(bus_mode), .cs_n_i(cs_n),
        .sel_i(sel), .strb_a_i(pa), .strb_b_i(pb), .data_i(din),
        .data_o(dout), .data_oe_o(oe), .tx_data_o(txd), .ctrl_b_o(ctlb),
        .tx_en_o(tx_en), .rx_en_o(rx_en), .osc_en_o(osc_en),
        .tone_oe_o(tone_oe), .irq_pull_o(irq), .rx_data_i(rxd),
        .rx_valid_i(rx_valid), .tx_done_i(tx_done)
    );

    task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic idle_pins();
        cs_n = 1'b1;
        pa   = 1'b1;
        pb   = bus_mode;
    endtask

    task automatic do_reset(input logic m);
        @(negedge clk);
        rst_n    = 1'b0;
        bus_mode = m;
        idle_pins();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic bus_write(input logic s, input logic [3:0] v);
        @(negedge clk);
        sel = s; din = v; cs_n = 1'b0;
        if (bus_mode) pa = 1'b0;
        else begin pa = 1'b0; pb = 1'b1; end
        repeat (5) @(negedge clk);
        idle_pins();
        repeat (6) @(negedge clk);
    endtask

    task automatic bus_read(input logic s, output logic [3:0] v, output logic e);
        @(negedge clk);
        sel = s; cs_n = 1'b0; pa = 1'b1;
        pb = bus_mode ? 1'b0 : 1'b1;
        repeat (3) @(negedge clk);
        v = dout; e = oe;
        idle_pins();
        repeat (6) @(negedge clk);
    endtask

    task automatic pulse_rx(input logic [3:0] v);
        @(negedge clk);
        rxd = v; rx_valid = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse_tx();
        @(negedge clk);
        tx_done = 1'b1;
        @(negedge clk);
        tx_done = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset_state();
        logic [3:0] v; logic e;
        check("R1 tx_en", {3'b0, tx_en}, 4'h0);
        check("R1 rx_en", {3'b0, rx_en}, 4'h0);
        check("R1 osc_en", {3'b0, osc_en}, 4'h0);
        check("R1 tone_oe", {3'b0, tone_oe}, 4'h0);
        check("R1 irq", {3'b0, irq}, 4'h0);
        check("R1 txd", txd, 4'h0);
        check("R1 ctrl_b", ctlb, 4'h0);
        bus_read(1'b1, v, e);
        check("R7 read in full power-down", {3'b0, e}, 4'h0);
    endtask

    task automatic t_write_ctrl();
        // hold a write strobe and look before its trailing edge
        @(negedge clk);
        sel = 1'b1; din = 4'b0111; cs_n = 1'b0; pa = 1'b0; pb = 1'b1;
        repeat (5) @(negedge clk);
        check("R11 no change during strobe", {3'b0, tx_en}, 4'h0);
        idle_pins();
        repeat (4) @(negedge clk);
        check("R11 commit after strobe", {3'b0, tx_en}, 4'h1);
        check("R6 tone_oe", {3'b0, tone_oe}, 4'h1);
        check("R6 rx_en", {3'b0, rx_en}, 4'h1);
        check("R6 osc_en", {3'b0, osc_en}, 4'h1);
        repeat (2) @(negedge clk);
    endtask

    task automatic t_tx_data();
        bus_write(1'b0, 4'b1010);
        check("R4 tx digit", txd, 4'b1010);
        bus_write(1'b0, 4'b0101);
        check("R4 tx digit second", txd, 4'b0101);
    endtask

    task automatic t_steer();
        bus_write(1'b1, 4'b1111);
        check("R5 steer keeps enables", {3'b0, tx_en}, 4'h1);
        bus_write(1'b1, 4'b0101);
        check("R5 secondary written", ctlb, 4'b0101);
        check("R5 primary kept", {2'b0, rx_en, tx_en}, 4'b0011);
        bus_write(1'b1, 4'b0011);
        check("R5 back to primary rx off", {3'b0, rx_en}, 4'h0);
        check("R5 secondary untouched", ctlb, 4'b0101);
        bus_write(1'b1, 4'b0111);
    endtask

    task automatic t_rx_irq();
        logic [3:0] v; logic e;
        pulse_rx(4'b1001);
        check("R9 irq on receive", {3'b0, irq}, 4'h1);
        bus_read(1'b0, v, e);
        check("R3 oe on read", {3'b0, e}, 4'h1);
        check("R4 rx digit", v, 4'b1001);
        bus_read(1'b1, v, e);
        check("R8 status rx", v, 4'b0110);
        check("R10 irq released", {3'b0, irq}, 4'h0);
        bus_read(1'b1, v, e);
        check("R10 status cleared", v, 4'b0000);
    endtask

    task automatic t_tx_irq();
        logic [3:0] v; logic e;
        pulse_tx();
        check("R9 irq on tx done", {3'b0, irq}, 4'h1);
        bus_read(1'b1, v, e);
        check("R8 status tx", v, 4'b0101);
        bus_write(1'b1, 4'b0101);
        pulse_tx();
        check("R9 irq masked", {3'b0, irq}, 4'h0);
        bus_read(1'b1, v, e);
        check("R8 status masked", v, 4'b0001);
    endtask

    task automatic t_oe_patterns();
        @(negedge clk);
        cs_n = 1'b1; pa = 1'b1; pb = 1'b1;
        @(negedge clk);
        check("R3 cs high no drive", {3'b0, oe}, 4'h0);
        cs_n = 1'b0; pa = 1'b1; pb = 1'b0;
        @(negedge clk);
        check("R3 strobe low no drive", {3'b0, oe}, 4'h0);
        idle_pins();
        repeat (3) @(negedge clk);
    endtask

    task automatic t_power();
        logic [3:0] v; logic e;
        bus_write(1'b1, 4'b0010);
        check("R7 tone released", {3'b0, tone_oe}, 4'h0);
        check("R6 osc off", {3'b0, osc_en}, 4'h0);
        pulse_tx();
        check("R7 irq released", {3'b0, irq}, 4'h0);
        bus_read(1'b0, v, e);
        check("R7 bus released", {3'b0, e}, 4'h0);
        bus_write(1'b1, 4'b0001);
        check("R6 tx only osc", {2'b0, osc_en, rx_en}, 4'b0010);
        pulse_rx(4'b0110);
        bus_read(1'b0, v, e);
        check("R4 rx ignored while off", v, 4'b1001);
        bus_read(1'b1, v, e);
        check("R8 no rx flag while off", v, 4'b0000);
        bus_write(1'b1, 4'b0100);
        check("R6 rx only", {1'b0, tone_oe, osc_en, rx_en}, 4'b0011);
    endtask

    task automatic t_mode1();
        logic [3:0] v; logic e;
        do_reset(1'b1);
        bus_mode = 1'b0;   // change after reset must not matter
        pb = 1'b1;         // keep the read strobe idle in mode 1
        bus_write(1'b1, 4'b0111);
        check("R2 mode1 write", {3'b0, tx_en}, 4'h1);
        bus_mode = 1'b1;
        bus_write(1'b0, 4'b0011);
        check("R2 mode1 tx digit", txd, 4'b0011);
        @(negedge clk);
        cs_n = 1'b0; pa = 1'b1; pb = 1'b1;
        @(negedge clk);
        check("R2 mode1 idle pins", {3'b0, oe}, 4'h0);
        idle_pins();
        repeat (3) @(negedge clk);
        bus_read(1'b1, v, e);
        check("R3 mode1 read oe", {3'b0, e}, 4'h1);
        check("R8 mode1 status", v, 4'b0000);
    endtask

    initial begin
        do_reset(1'b0);
        t_reset_state();
        t_write_ctrl();
        t_tx_data();
        t_steer();
        t_rx_irq();
        t_tx_irq();
        t_oe_patterns();
        t_power();
        t_mode1();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule